// File: doc/BRIEF.md
# Monochrome STN Panel Timing Controller

This block streams a frame buffer from memory to a single-scan monochrome STN panel. An address generator walks the frame buffer in 16-bit words. It starts at a programmable base word address and returns to that base once the configured number of words has been read. Words come back through a simple request/ready read port with in-order `mem_rvalid` responses. They land in a small prefetch FIFO. The number of words stored plus the number still in flight is held to the FIFO depth, so the FIFO can never overflow.

An unpacker cuts each word into groups of four pixels at 1, 2 or 4 bits per pixel. When a pixel has more than one bit, only its most significant bit goes to the panel. A timing engine presents one group on the 4-bit data bus per pixel-clock slot. It ends every line with one line-clock slot. It holds the frame pulse high for the whole first line of a frame, and it flips the AC-bias output at each new frame. The panel timing starts only after the prefetch FIFO has filled once. If a group is needed and no data is ready, the engine sends zeros and raises a sticky underrun flag.

All configuration inputs are static: they change only while `rst_n` is low. The panel width is given in 16-pixel units (2 to 64, that is 32 to 1024 pixels). The frame buffer may be up to 65536 words (128 KB).

Top module: `lcd_stn_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `lcd_pclk`, `lcd_lclk`, `lcd_frm`, `lcd_m`, `lcd_dd` and `underrun` are all 0.
- R2: The first accepted read (`mem_req && mem_ready`) after reset has address `cfg_base`. Each following accepted read has the previous address plus one, modulo 2^16, unless R3 applies.
- R3: After `cfg_frame_words` reads have been accepted, the next accepted read returns to address `cfg_base`.
- R4: With `cfg_bpp` = 0 (1 bpp), each word supplies four groups in order g = 0..3, and `lcd_dd[k]` = word bit 4g+k.
- R5: With `cfg_bpp` = 1 (2 bpp), each word supplies two groups in order g = 0..1, and `lcd_dd[k]` = word bit 8g+2k+1.
- R6: With `cfg_bpp` = 2 (4 bpp), each word supplies one group, and `lcd_dd[k]` = word bit 4k+3.
- R7: Each line has exactly `cfg_width16`*4 rising edges of `lcd_pclk`, followed by exactly one `lcd_lclk` pulse. `lcd_pclk` and `lcd_lclk` are never high together.
- R8: `cfg_lines` (at least 2) lines form a frame. `lcd_frm` is high at every pixel clock of the first line of a frame and low at every pixel clock of the other lines.
- R9: `lcd_m` is constant within a frame. It changes exactly when a new frame begins, and at no other time.
- R10: If a group is due while no data is ready, `lcd_dd` is 0 for that group and `underrun` rises. `underrun` then stays high until reset. Under normal memory service it stays 0.
- R11: The words stored in the FIFO plus the reads in flight never exceed `FIFO_DEPTH`. If no responses return, `mem_req` falls after `FIFO_DEPTH` accepted reads. `lcd_pclk` stays low until the FIFO has filled once.
- R12: Each group slot lasts 2*`PCLK_HALF` cycles, with `lcd_pclk` high in the second half. `lcd_dd` changes only at slot starts, so it is stable while `lcd_pclk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | ADDR_W | Frame buffer start word address |
| cfg_frame_words | input | ADDR_W+1 | Frame buffer size in words (1 to 2^ADDR_W) |
| cfg_width16 | input | WIDTH_W | Panel width in 16-pixel units |
| cfg_lines | input | LINE_W | Lines per frame |
| cfg_bpp | input | 2 | Depth select: 0 = 1 bpp, 1 = 2 bpp, 2 = 4 bpp |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADDR_W | Read word address |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid, in request order |
| mem_rdata | input | 16 | Read data |
| lcd_pclk | output | 1 | Pixel clock |
| lcd_lclk | output | 1 | Line clock |
| lcd_frm | output | 1 | Frame pulse |
| lcd_m | output | 1 | AC-bias toggle |
| lcd_dd | output | 4 | Panel data bus, four pixels per pixel clock |
| underrun | output | 1 | Sticky underrun flag |

## Verification
Some rules are checked by the assertions on every cycle:
- the credit bound between FIFO contents and reads in flight;
- the address step and wrap;
- pixel clock and line clock never high together;
- data held stable while the pixel clock is high;
- `lcd_m` changing only when a frame begins;
- the underrun flag never clearing.

Other behaviour needs the bench's scenarios, with a memory model whose contents are known:
- the bit positions picked for each depth and the group order within a word;
- the number of groups per line and the lines per frame;
- the frame pulse placement;
- the zero data sent during a forced memory stall.

// File: rtl/lcd_stn_pkg.sv
package lcd_stn_pkg;

  localparam int unsigned WORD_W       = 16;
  localparam int unsigned BUS_W        = 4;
  localparam int unsigned PIX_PER_UNIT = 16;
  localparam int unsigned GRP_IDX_W    = $clog2(WORD_W / BUS_W);
  localparam int unsigned BITSEL_W     = $clog2(WORD_W);

  typedef enum logic [1:0] {
    DEPTH_1 = 2'd0,
    DEPTH_2 = 2'd1,
    DEPTH_4 = 2'd2
  } depth_e;

  // bits per pixel for a depth selector; reserved code behaves as 4 bpp
  function automatic int unsigned bits_per_pixel(logic [1:0] sel);
    case (depth_e'(sel))
      DEPTH_1: return 1;
      DEPTH_2: return 2;
      default: return 4;
    endcase
  endfunction

  // index of the last four-pixel group held in one word
  function automatic logic [GRP_IDX_W-1:0] last_group(logic [1:0] sel);
    return GRP_IDX_W'(WORD_W / (BUS_W * bits_per_pixel(sel)) - 1);
  endfunction

  // MSB of each of the four pixels of group g
  function automatic logic [BUS_W-1:0] pick_group(logic [WORD_W-1:0] w,
                                                  logic [1:0] sel,
                                                  logic [GRP_IDX_W-1:0] g);
    logic [BUS_W-1:0] r;
    int unsigned bpp;
    int unsigned idx;
    bpp = bits_per_pixel(sel);
    for (int k = 0; k < int'(BUS_W); k++) begin
      idx  = (32'(g) * BUS_W + 32'(k)) * bpp + bpp - 1;
      r[k] = w[idx[BITSEL_W-1:0]];
    end
    return r;
  endfunction

  // pixel-clock groups in one line
  function automatic int unsigned line_groups(int unsigned w16);
    return w16 * (PIX_PER_UNIT / BUS_W);
  endfunction

endpackage

// File: rtl/lcd_fifo.sv
module lcd_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);

  logic [W-1:0]     store [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= step(wr_q);
      if (pop)  rd_q <= step(rd_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout  = store[rd_q];
  assign count = cnt_q;
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/lcd_fetch.sv
module lcd_fetch #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W:0]   cfg_frame_words,
  input  logic [CNT_W-1:0]  fifo_count,
  input  logic              rsp_valid,
  input  logic              mem_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr
);

  logic [ADDR_W:0]  idx_q;
  logic [CNT_W-1:0] outst_q;
  logic [CNT_W:0]   credit_used;
  logic             accept;
  logic             last_word;

  assign credit_used = {1'b0, fifo_count} + {1'b0, outst_q};
  assign mem_req     = (credit_used < (CNT_W+1)'(DEPTH));
  assign accept      = mem_req && mem_ready;
  assign last_word   = (idx_q == cfg_frame_words - 1'b1);
  assign mem_addr    = cfg_base + idx_q[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      outst_q <= '0;
    end else begin
      if (accept) idx_q <= last_word ? '0 : idx_q + 1'b1;
      case ({accept, rsp_valid})
        2'b10:   outst_q <= outst_q + 1'b1;
        2'b01:   outst_q <= outst_q - 1'b1;
        default: outst_q <= outst_q;
      endcase
    end
  end

  assert_credit_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    credit_used <= (CNT_W+1)'(DEPTH));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !last_word) |=> (mem_addr == $past(mem_addr) + 1'b1));

  assert_addr_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && last_word) |=> (mem_addr == cfg_base));

endmodule

// File: rtl/lcd_unpack.sv
module lcd_unpack
  import lcd_stn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_bpp,
  input  logic [WORD_W-1:0] fifo_dout,
  input  logic              fifo_empty,
  output logic              fifo_pop,
  input  logic              grp_take,
  output logic              grp_valid,
  output logic [BUS_W-1:0]  grp_data
);

  logic [WORD_W-1:0]    cur_q;
  logic                 cur_valid_q;
  logic [GRP_IDX_W-1:0] gidx_q;
  logic                 at_last;
  logic                 consume;
  logic                 load;

  assign at_last  = (gidx_q == last_group(cfg_bpp));
  assign consume  = grp_take && cur_valid_q;
  assign load     = !fifo_empty && (!cur_valid_q || (consume && at_last));
  assign fifo_pop = load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q       <= '0;
      cur_valid_q <= 1'b0;
      gidx_q      <= '0;
    end else if (load) begin
      cur_q       <= fifo_dout;
      cur_valid_q <= 1'b1;
      gidx_q      <= '0;
    end else if (consume) begin
      if (at_last) cur_valid_q <= 1'b0;
      else         gidx_q      <= gidx_q + 1'b1;
    end
  end

  assign grp_valid = cur_valid_q;
  assign grp_data  = pick_group(cur_q, cfg_bpp, gidx_q);

  assert_group_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cur_valid_q |-> (gidx_q <= last_group(cfg_bpp)));

endmodule

// File: rtl/lcd_timing.sv
module lcd_timing
  import lcd_stn_pkg::*;
#(
  parameter int WIDTH_W   = 7,
  parameter int LINE_W    = 10,
  parameter int PCLK_HALF = 1,
  localparam int GC_W = WIDTH_W + $clog2(PIX_PER_UNIT / BUS_W),
  localparam int PH_W = (2 * PCLK_HALF > 2) ? $clog2(2 * PCLK_HALF) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH_W-1:0] cfg_width16,
  input  logic [LINE_W-1:0]  cfg_lines,
  input  logic               grp_valid,
  input  logic [BUS_W-1:0]   grp_data,
  output logic               grp_take,
  output logic               pclk,
  output logic               lclk,
  output logic               frm,
  output logic               m,
  output logic [BUS_W-1:0]   dd,
  output logic               underrun
);

  logic              running_q, lslot_q, m_q, under_q;
  logic [PH_W-1:0]   phase_q;
  logic [GC_W-1:0]   grp_q;
  logic [LINE_W-1:0] line_q;
  logic [BUS_W-1:0]  dd_q;

  logic slot_start, slot_end, second_half, line_done, frame_wrap, starve;

  assign slot_start  = running_q && (phase_q == '0);
  assign slot_end    = running_q && (phase_q == PH_W'(2 * PCLK_HALF - 1));
  assign second_half = (phase_q >= PH_W'(PCLK_HALF));
  assign grp_take    = slot_start && !lslot_q;
  assign starve      = grp_take && !grp_valid;
  assign line_done   = slot_end && !lslot_q &&
                       (grp_q == GC_W'(line_groups(32'(cfg_width16)) - 1));
  assign frame_wrap  = slot_end && lslot_q && (line_q == cfg_lines - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      lslot_q   <= 1'b0;
      m_q       <= 1'b0;
      under_q   <= 1'b0;
      phase_q   <= '0;
      grp_q     <= '0;
      line_q    <= '0;
      dd_q      <= '0;
    end else if (!running_q) begin
      if (start) running_q <= 1'b1;
    end else begin
      phase_q <= slot_end ? '0 : phase_q + 1'b1;
      if (grp_take) dd_q <= grp_valid ? grp_data : '0;
      if (starve) under_q <= 1'b1;
      if (slot_end) begin
        if (!lslot_q) begin
          if (line_done) begin
            lslot_q <= 1'b1;
            grp_q   <= '0;
          end else begin
            grp_q <= grp_q + 1'b1;
          end
        end else begin
          lslot_q <= 1'b0;
          if (frame_wrap) begin
            line_q <= '0;
            m_q    <= ~m_q;
          end else begin
            line_q <= line_q + 1'b1;
          end
        end
      end
    end
  end

  assign pclk     = running_q && !lslot_q && second_half;
  assign lclk     = running_q && lslot_q && second_half;
  assign frm      = running_q && (line_q == '0);
  assign m        = m_q;
  assign dd       = dd_q;
  assign underrun = under_q;

  assert_clk_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pclk && lclk));

  assert_dd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pclk && $past(pclk)) |-> $stable(dd));

  assert_m_at_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(m) |-> $rose(frm));

  assert_underrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  assert_starve_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    starve |=> (dd == '0));

endmodule

// File: rtl/lcd_stn_ctrl.sv
module lcd_stn_ctrl
  import lcd_stn_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WIDTH_W    = 7,
  parameter int LINE_W     = 10,
  parameter int FIFO_DEPTH = 4,
  parameter int PCLK_HALF  = 1,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [ADDR_W:0]    cfg_frame_words,
  input  logic [WIDTH_W-1:0] cfg_width16,
  input  logic [LINE_W-1:0]  cfg_lines,
  input  logic [1:0]         cfg_bpp,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               mem_ready,
  input  logic               mem_rvalid,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic               lcd_pclk,
  output logic               lcd_lclk,
  output logic               lcd_frm,
  output logic               lcd_m,
  output logic [BUS_W-1:0]   lcd_dd,
  output logic               underrun
);

  logic [WORD_W-1:0] fifo_dout;
  logic [CNT_W-1:0]  fifo_count;
  logic              fifo_empty, fifo_full, fifo_pop;
  logic              grp_take, grp_valid;
  logic [BUS_W-1:0]  grp_data;
  logic              primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         primed_q <= 1'b0;
    else if (fifo_full) primed_q <= 1'b1;
  end

  lcd_fetch #(.ADDR_W(ADDR_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_fetch (
    .clk, .rst_n, .cfg_base, .cfg_frame_words,
    .fifo_count, .rsp_valid(mem_rvalid), .mem_ready,
    .mem_req, .mem_addr
  );

  lcd_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk, .rst_n, .push(mem_rvalid), .din(mem_rdata), .pop(fifo_pop),
    .dout(fifo_dout), .count(fifo_count), .empty(fifo_empty), .full(fifo_full)
  );

  lcd_unpack u_unpack (
    .clk, .rst_n, .cfg_bpp, .fifo_dout, .fifo_empty, .fifo_pop,
    .grp_take, .grp_valid, .grp_data
  );

  lcd_timing #(.WIDTH_W(WIDTH_W), .LINE_W(LINE_W), .PCLK_HALF(PCLK_HALF)) u_timing (
    .clk, .rst_n, .start(primed_q), .cfg_width16, .cfg_lines,
    .grp_valid, .grp_data, .grp_take,
    .pclk(lcd_pclk), .lclk(lcd_lclk), .frm(lcd_frm), .m(lcd_m),
    .dd(lcd_dd), .underrun
  );

  assert_start_after_prime_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_pclk |-> primed_q);

endmodule

// File: tb/lcd_stn_ctrl_bench.sv
`timescale 1ns/1ps
module lcd_stn_ctrl_bench;

  localparam int ADDR_W = 16, WIDTH_W = 7, LINE_W = 10, DEPTH = 4;

  typedef struct packed {
    logic [1:0]  bpp;
    logic [6:0]  w16;
    logic [9:0]  lines;
    logic [16:0] fw;
    logic [15:0] base;
    logic [15:0] ngrp;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 7'd2,  10'd3, 17'd6,   16'h0100, 16'd72},
    '{2'd1, 7'd3,  10'd2, 17'd12,  16'hFFFA, 16'd60},
    '{2'd2, 7'd2,  10'd4, 17'd32,  16'h2000, 16'd80},
    '{2'd0, 7'd64, 10'd2, 17'd128, 16'h0040, 16'd600},
    '{2'd2, 7'd5,  10'd3, 17'd60,  16'h7FF0, 16'd150}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0]  cfg_base = '0;
  logic [ADDR_W:0]    cfg_frame_words = 17'd1;
  logic [WIDTH_W-1:0] cfg_width16 = 7'd2;
  logic [LINE_W-1:0]  cfg_lines = 10'd2;
  logic [1:0]         cfg_bpp = 2'd0;
  logic               mem_req;
  logic [ADDR_W-1:0]  mem_addr;
  logic               mem_ready = 1'b0;
  logic               mem_rvalid = 1'b0;
  logic [15:0]        mem_rdata = '0;
  logic               lcd_pclk, lcd_lclk, lcd_frm, lcd_m, underrun;
  logic [3:0]         lcd_dd;

  always #4 clk = ~clk;

  lcd_stn_ctrl u_lcd_stn_ctrl (
    .clk, .rst_n, .cfg_base, .cfg_frame_words, .cfg_width16, .cfg_lines, .cfg_bpp,
    .mem_req, .mem_addr, .mem_ready, .mem_rvalid, .mem_rdata,
    .lcd_pclk, .lcd_lclk, .lcd_frm, .lcd_m, .lcd_dd, .underrun
  );

  int n_checks = 0;
  int n_fail = 0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] mem_word(logic [15:0] a);
    logic [15:0] p;
    p = a * 16'h9E37;
    return p ^ 16'h5A3C;
  endfunction

  function automatic logic [3:0] exp_group(logic [15:0] w, logic [1:0] sel, int g);
    int bw;
    logic [15:0] s;
    logic [3:0] r;
    bw = (sel == 2'd0) ? 1 : (sel == 2'd1) ? 2 : 4;
    s = w >> (g * 4 * bw);
    for (int k = 0; k < 4; k++) r[k] = s[k * bw + bw - 1];
    return r;
  endfunction

  // memory model: fixed two-stage latency, driven away from the active edge
  logic stall = 1'b0, frozen = 1'b0;
  logic p0_v = 1'b0, p1_v = 1'b0;
  logic [15:0] p0_d = '0, p1_d = '0;
  int aidx = 0, acc_n = 0;

  always @(negedge clk) begin
    logic rdy, acc;
    if (!rst_n) begin
      p0_v = 1'b0; p1_v = 1'b0; mem_rvalid = 1'b0; mem_ready = 1'b0;
      aidx = 0; acc_n = 0;
    end else begin
      mem_rvalid = p1_v;
      mem_rdata  = p1_d;
      p1_v = p0_v; p1_d = p0_d;
      rdy = !stall;
      mem_ready = rdy;
      acc = mem_req && rdy;
      p0_v = acc && !frozen;
      if (acc) begin
        check(mem_addr == 16'(cfg_base + 16'(aidx)), (aidx == 0 && acc_n > 0) ? "R3" : "R2",
              int'(mem_addr), int'(16'(cfg_base + 16'(aidx))));
        p0_d = mem_word(mem_addr);
        aidx = (aidx == int'(cfg_frame_words) - 1) ? 0 : aidx + 1;
        acc_n++;
      end
    end
  end

  // panel monitor
  logic mon_data = 1'b0;
  logic pclk_q = 1'b0, lclk_q = 1'b0, m_prev = 1'b0, m_known = 1'b0, ur_seen = 1'b0;
  logic [3:0] dd_at_rise = '0;
  int widx = 0, wg = 0, egrp = 0, eline = 0, grp_total = 0;

  always @(negedge clk) begin
    logic [3:0] e;
    int gpw;
    if (!rst_n) begin
      pclk_q = 1'b0; lclk_q = 1'b0; m_known = 1'b0; ur_seen = 1'b0;
      widx = 0; wg = 0; egrp = 0; eline = 0; grp_total = 0;
    end else begin
      if (lcd_pclk && !pclk_q) begin
        dd_at_rise = lcd_dd;
        check(!lcd_lclk, "R7", int'(lcd_lclk), 0);
        check(lcd_frm == (eline == 0), "R8", int'(lcd_frm), int'(eline == 0));
        if (egrp == 0) begin
          if (eline == 0) begin
            if (m_known) check(lcd_m != m_prev, "R9", int'(lcd_m), int'(!m_prev));
            m_prev = lcd_m; m_known = 1'b1;
          end else begin
            check(lcd_m == m_prev, "R9", int'(lcd_m), int'(m_prev));
          end
        end
        if (underrun && !ur_seen) begin
          ur_seen = 1'b1;
          check(lcd_dd == 4'd0, "R10", int'(lcd_dd), 0);
        end
        if (mon_data) begin
          e = exp_group(mem_word(16'(cfg_base + 16'(widx))), cfg_bpp, wg);
          check(lcd_dd == e, (cfg_bpp == 2'd0) ? "R4" : (cfg_bpp == 2'd1) ? "R5" : "R6",
                int'(lcd_dd), int'(e));
          gpw = (cfg_bpp == 2'd0) ? 4 : (cfg_bpp == 2'd1) ? 2 : 1;
          if (wg == gpw - 1) begin
            wg = 0;
            widx = (widx == int'(cfg_frame_words) - 1) ? 0 : widx + 1;
          end else begin
            wg++;
          end
        end
        egrp++;
        grp_total++;
      end
      if (!lcd_pclk && pclk_q)
        check(lcd_dd == dd_at_rise, "R12", int'(lcd_dd), int'(dd_at_rise));
      if (lcd_lclk && !lclk_q) begin
        check(egrp == int'(cfg_width16) * 4, "R7", egrp, int'(cfg_width16) * 4);
        check(!lcd_pclk, "R7", int'(lcd_pclk), 0);
        egrp = 0;
        eline = (eline == int'(cfg_lines) - 1) ? 0 : eline + 1;
      end
      pclk_q = lcd_pclk;
      lclk_q = lcd_lclk;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog R7 actual=timeout expected=progress");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  task automatic reset_checks();
    check(!lcd_pclk && !lcd_lclk && !lcd_frm && !lcd_m && !underrun && lcd_dd == 4'd0,
          "R1", {lcd_pclk, lcd_lclk, lcd_frm, lcd_m, underrun, lcd_dd}, 0);
  endtask

  task automatic do_reset(input vec_t v);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_bpp = v.bpp; cfg_width16 = v.w16; cfg_lines = v.lines;
    cfg_frame_words = v.fw; cfg_base = v.base;
    repeat (3) @(negedge clk);
    reset_checks();
    rst_n = 1'b1;
    @(negedge clk);
    reset_checks();
  endtask

  initial begin
    // table walk: each vector is a panel/buffer setup with its group budget
    for (int v = 0; v < NV; v++) begin
      mon_data = 1'b1;
      do_reset(VECS[v]);
      while (grp_total < int'(VECS[v].ngrp)) @(negedge clk);
      check(!underrun, "R10", int'(underrun), 0);
    end

    // R11: no responses, requests stop at the FIFO depth and the panel stays idle
    frozen = 1'b1;
    mon_data = 1'b0;
    do_reset(VECS[0]);
    repeat (30) @(negedge clk);
    check(acc_n == DEPTH, "R11", acc_n, DEPTH);
    check(!mem_req, "R11", int'(mem_req), 0);
    check(grp_total == 0, "R11", grp_total, 0);
    frozen = 1'b0;

    // R10: starve the engine with a memory stall
    do_reset(VECS[2]);
    while (grp_total < 20) @(negedge clk);
    check(!underrun, "R10", int'(underrun), 0);
    stall = 1'b1;
    repeat (40) @(negedge clk);
    stall = 1'b0;
    begin
      int target;
      target = grp_total + 20;
      while (grp_total < target) @(negedge clk);
    end
    check(underrun, "R10", int'(underrun), 1);
    check(ur_seen, "R10", int'(ur_seen), 1);

    // R1 again after a run: reset clears the sticky flag
    do_reset(VECS[1]);
    check(!underrun, "R1", int'(underrun), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule